// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit with Merge Loads

This unit sits between an execute stage and a 32-bit data memory that is organised as words. For each request it adds a sign-extended 16-bit displacement to a 32-bit base value to form a byte address. It rejects accesses whose size does not fit the address alignment. Accepted accesses go to memory as one word-address request, and stores carry a 4-bit byte-enable mask.

Load results come back one cycle later. They are cut down to a byte or halfword, then sign- or zero-extended as the operation asks. Two merge loads, fill-high and fill-low, take bytes from the one aligned word that holds the address. They combine those bytes with the current destination value supplied on `dest_old_i`. Used as a pair, the two merge loads assemble a word that crosses a word boundary.

Byte-lane placement follows `big_endian_i`, which may change from one request to the next.

Top module: `lsu_word_port`

## Requirements
- R1: The byte address is `base_i` plus `offset_i` sign-extended to 32 bits. `mem_addr_o` carries bits 31:2 of that sum in the request cycle.
- R2: A misaligned access raises `align_err_o` in the request cycle, and no memory access takes place: `mem_req_o` stays low and `load_valid_o` stays low in the next cycle. A word access is misaligned when address bits 1:0 are not 00. A halfword access is misaligned when address bit 0 is 1.
- R3: Let a be address bits 1:0. The byte at offset a sits in lane a (bits 8a+7:8a) when `big_endian_i`=0, and in lane 3-a when `big_endian_i`=1.
- R4: `op_i` codes: 0 word load, 1 signed halfword, 2 unsigned halfword, 3 signed byte, 4 unsigned byte, 5 fill-high merge, 6 fill-low merge, 8 word store, 9 halfword store, 10 byte store. Each accepted load raises `load_valid_o` for exactly the following cycle, with its result on `load_data_o`.
- R5: Signed byte and halfword loads sign-extend to 32 bits, and the unsigned variants zero-extend. For a halfword at offset a, the byte at offset a is the high byte in big-endian mode and the low byte in little-endian mode.
- R6: A fill-high merge (code 5) puts the addressed byte, in lane L, into result bits 31:24, followed by lanes L-1 down to 0. The lowest 3-L result bytes are kept from `dest_old_i`.
- R7: A fill-low merge (code 6) puts the addressed byte, in lane L, into result bits 7:0, followed by lanes L+1 up to 3. The highest L result bytes are kept from `dest_old_i`.
- R8: Merge loads never raise `align_err_o`, at any offset. They read only the aligned word that contains the address.
- R9: A word store enables all four lanes (mask 1111). A halfword store enables the two lanes of the halfword and places the low 16 data bits in both halves. A byte store enables one lane and places the low 8 data bits in all four lanes. `mem_be_o` is 0000 when no store is issued.
- R10: A fill-high merge at address A followed by a fill-low merge at A+3 yields the unaligned big-endian word at A, when the first result is fed back as the destination value. In little-endian mode the order is reversed: fill-low at A, then fill-high at A+3.
- R11: While reset is applied and just after it, `load_valid_o` is low, and `mem_req_o` is low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| op_i | input | 4 | Operation code (see R4) |
| big_endian_i | input | 1 | 1 selects big-endian lane placement |
| base_i | input | 32 | Base address value |
| offset_i | input | 16 | Signed displacement |
| store_data_i | input | 32 | Store data, right-aligned |
| dest_old_i | input | 32 | Current destination value for merge loads |
| align_err_o | output | 1 | Alignment exception for the current request |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte write enables, bit i is lane i |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word, one cycle after the request |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Formatted load result |

## Verification
The bench targets the lane arithmetic in both endian modes. A swapped mapping shows up as a wrong byte in a byte or halfword load, or as a mask on the mirror lane. It drives merge loads at several offsets with a known destination value. An off-by-one in the kept-byte boundary either drops a destination byte or lets a memory byte leak into it. Both split-word pairs are assembled to confirm the two merge directions fit together. A misaligned word store is followed by a read-back, to catch a unit that flags the error but still writes. Negative displacements and sign extension of bytes with the top bit set round out the cases.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_LW  = 4'h0,
    OP_LH  = 4'h1,
    OP_LHU = 4'h2,
    OP_LB  = 4'h3,
    OP_LBU = 4'h4,
    OP_LFH = 4'h5,
    OP_LFL = 4'h6,
    OP_SW  = 4'h8,
    OP_SH  = 4'h9,
    OP_SB  = 4'hA
  } lsu_op_e;

  function automatic logic op_is_load(lsu_op_e op);
    return op inside {OP_LW, OP_LH, OP_LHU, OP_LB, OP_LBU, OP_LFH, OP_LFL};
  endfunction

  function automatic logic op_is_store(lsu_op_e op);
    return op inside {OP_SW, OP_SH, OP_SB};
  endfunction

  function automatic logic op_is_word(lsu_op_e op);
    return op inside {OP_LW, OP_SW};
  endfunction

  function automatic logic op_is_half(lsu_op_e op);
    return op inside {OP_LH, OP_LHU, OP_SH};
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  lsu_op_e           op_i,
  input  logic              big_endian_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [LANE_W-1:0] lane_o,
  output logic [LANE_W-1:0] hlane_o,
  output logic              misalign_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;
  localparam logic [LANE_W-1:0] TOP_LANE  = LANE_W'(LANES - 1);
  localparam logic [LANE_W-1:0] HTOP_LANE = LANE_W'(LANES - 2);

  logic [LANE_W-1:0] ofs;

  assign ea_o = base_i + {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign ofs  = ea_o[LANE_W-1:0];

  // lane of the addressed byte, and low lane of the addressed halfword
  always_comb begin
    if (big_endian_i) begin
      lane_o  = TOP_LANE - ofs;
      hlane_o = HTOP_LANE - ofs;
    end else begin
      lane_o  = ofs;
      hlane_o = ofs;
    end
  end

  assign misalign_o = (op_is_word(op_i) && (ofs != '0)) ||
                      (op_is_half(op_i) && ofs[0]);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  lsu_op_e           op_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_W-1:0] hlane_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o
);
  always_comb begin
    be_o    = '0;
    wdata_o = data_i;
    unique case (op_i)
      OP_SW: be_o = '1;
      OP_SH: begin
        be_o    = LANES'(2'b11) << hlane_i;
        wdata_o = {(LANES/2){data_i[15:0]}};
      end
      OP_SB: begin
        be_o    = LANES'(1'b1) << lane_i;
        wdata_o = {LANES{data_i[7:0]}};
      end
      default: be_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  lsu_op_e           op_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [LANE_W-1:0] hlane_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic [WORD_W-1:0] old_i,
  output logic [WORD_W-1:0] data_o
);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  logic [7:0]        byte_v;
  logic [15:0]       half_v;
  logic [WORD_W-1:0] shl, shr, merge_hi, merge_lo;
  logic [LANE_W-1:0] keep_t;

  assign byte_v = 8'(rdata_i >> (8 * int'(lane_i)));
  assign half_v = 16'(rdata_i >> (8 * int'(hlane_i)));
  assign keep_t = TOP_LANE - lane_i;
  assign shl    = rdata_i << (8 * int'(keep_t));
  assign shr    = rdata_i >> (8 * int'(lane_i));

  // per lane: keep destination byte or take shifted memory byte
  for (genvar k = 0; k < LANES; k++) begin : g_merge
    assign merge_hi[8*k +: 8] = (LANE_W'(k) < keep_t) ? old_i[8*k +: 8] : shl[8*k +: 8];
    assign merge_lo[8*k +: 8] = (LANE_W'(k) > keep_t) ? old_i[8*k +: 8] : shr[8*k +: 8];
  end

  always_comb begin
    unique case (op_i)
      OP_LH:   data_o = {{(WORD_W-16){half_v[15]}}, half_v};
      OP_LHU:  data_o = {{(WORD_W-16){1'b0}}, half_v};
      OP_LB:   data_o = {{(WORD_W-8){byte_v[7]}}, byte_v};
      OP_LBU:  data_o = {{(WORD_W-8){1'b0}}, byte_v};
      OP_LFH:  data_o = merge_hi;
      OP_LFL:  data_o = merge_lo;
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_word_port.sv
module lsu_word_port
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [3:0]               op_i,
  input  logic                     big_endian_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFF_W-1:0]         offset_i,
  input  logic [WORD_W-1:0]        store_data_i,
  input  logic [WORD_W-1:0]        dest_old_i,
  output logic                     align_err_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-LANE_W-1:0] mem_addr_o,
  output logic [LANES-1:0]         mem_be_o,
  output logic [WORD_W-1:0]        mem_wdata_o,
  input  logic [WORD_W-1:0]        mem_rdata_i,
  output logic                     load_valid_o,
  output logic [WORD_W-1:0]        load_data_o
);
  lsu_op_e           op;
  logic [ADDR_W-1:0] ea;
  logic [LANE_W-1:0] lane, hlane;
  logic              misalign, known, access, is_ld;
  logic [LANES-1:0]  st_be;

  lsu_op_e           op_q;
  logic [LANE_W-1:0] lane_q, hlane_q;
  logic [WORD_W-1:0] old_q;
  logic              vld_q;

  assign op = lsu_op_e'(op_i);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_i       (base_i),
    .off_i        (offset_i),
    .op_i         (op),
    .big_endian_i (big_endian_i),
    .ea_o         (ea),
    .lane_o       (lane),
    .hlane_o      (hlane),
    .misalign_o   (misalign)
  );

  lsu_store_lane u_st (
    .op_i    (op),
    .lane_i  (lane),
    .hlane_i (hlane),
    .data_i  (store_data_i),
    .be_o    (st_be),
    .wdata_o (mem_wdata_o)
  );

  assign is_ld  = op_is_load(op);
  assign known  = is_ld || op_is_store(op);
  assign access = req_valid_i && known && !misalign;

  assign align_err_o = req_valid_i && misalign;
  assign mem_req_o   = access;
  assign mem_we_o    = access && !is_ld;
  assign mem_addr_o  = ea[ADDR_W-1:LANE_W];
  assign mem_be_o    = mem_we_o ? st_be : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      op_q    <= OP_LW;
      lane_q  <= '0;
      hlane_q <= '0;
      old_q   <= '0;
    end else begin
      vld_q <= access && is_ld;
      if (access && is_ld) begin
        op_q    <= op;
        lane_q  <= lane;
        hlane_q <= hlane;
        old_q   <= dest_old_i;
      end
    end
  end

  lsu_load_fmt u_ld (
    .op_i    (op_q),
    .lane_i  (lane_q),
    .hlane_i (hlane_q),
    .rdata_i (mem_rdata_i),
    .old_i   (old_q),
    .data_o  (load_data_o)
  );

  assign load_valid_o = vld_q;
endmodule

// File: rtl/lsu_word_port_chk.sv
module lsu_word_port_chk
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [3:0]               op_i,
  input logic [ADDR_W-1:0]        base_i,
  input logic [OFF_W-1:0]         offset_i,
  input logic                     align_err_o,
  input logic                     mem_req_o,
  input logic                     mem_we_o,
  input logic [ADDR_W-LANE_W-1:0] mem_addr_o,
  input logic [LANES-1:0]         mem_be_o,
  input logic                     load_valid_o
);
  logic [ADDR_W-1:0] sum;
  logic              rd_go;
  assign sum   = base_i + ADDR_W'($signed(offset_i));
  assign rd_go = mem_req_o && !mem_we_o;

  p_word_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o == sum[ADDR_W-1:LANE_W]);

  p_no_access_on_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !mem_req_o);

  p_fault_needs_request_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !align_err_o && !mem_req_o);

  p_result_follows_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go |=> load_valid_o);

  p_no_stray_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> !load_valid_o);

  p_merge_never_faults_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_i == 4'h5 || op_i == 4'h6)) |-> !align_err_o && mem_req_o && !mem_we_o);

  p_mask_shape_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                  $countones(mem_be_o) == LANES));

  p_mask_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_o |-> mem_be_o == '0);
endmodule

bind lsu_word_port lsu_word_port_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .op_i         (op_i),
  .base_i       (base_i),
  .offset_i     (offset_i),
  .align_err_o  (align_err_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .load_valid_o (load_valid_o)
);

// File: tb/lsu_word_port_bench.sv
`timescale 1ns/1ps
module lsu_word_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        big = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] off = '0;
  logic [31:0] sdata = '0;
  logic [31:0] old = '0;
  logic        align_err, mem_req, mem_we, load_valid;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, load_data;

  logic [31:0] mem [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsu_word_port u_lsu_word_port (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .op_i(op),
    .big_endian_i(big), .base_i(base), .offset_i(off), .store_data_i(sdata),
    .dest_old_i(old), .align_err_o(align_err), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .load_valid_o(load_valid), .load_data_o(load_data)
  );

  // word memory model: synchronous read, per-lane write
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
      mem[0] <= 32'h11223344;
      mem[1] <= 32'h8899AABB;
      mem[2] <= 32'hC0D0E0F0;
      mem_rdata <= 32'h0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  typedef struct packed {
    logic [3:0]  op;
    logic        be;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] old;
    logic [31:0] exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 1'b0, 32'd4, 16'h0000, 32'h0,        32'h8899AABB, 8'd4}, // R4
    '{4'h0, 1'b1, 32'd8, 16'hFFFC, 32'h0,        32'h8899AABB, 8'd1}, // R1
    '{4'h3, 1'b0, 32'd4, 16'h0001, 32'h0,        32'hFFFFFFAA, 8'd5}, // R5
    '{4'h4, 1'b0, 32'd4, 16'h0001, 32'h0,        32'h000000AA, 8'd5}, // R5
    '{4'h3, 1'b1, 32'd4, 16'h0001, 32'h0,        32'hFFFFFF99, 8'd3}, // R3
    '{4'h4, 1'b1, 32'd4, 16'h0003, 32'h0,        32'h000000BB, 8'd3}, // R3
    '{4'h1, 1'b0, 32'd4, 16'h0002, 32'h0,        32'hFFFF8899, 8'd5}, // R5
    '{4'h2, 1'b1, 32'd4, 16'h0002, 32'h0,        32'h0000AABB, 8'd5}, // R5
    '{4'h1, 1'b1, 32'd0, 16'h0000, 32'h0,        32'h00001122, 8'd5}, // R5
    '{4'h5, 1'b1, 32'd4, 16'h0001, 32'h01020304, 32'h99AABB04, 8'd6}, // R6
    '{4'h6, 1'b1, 32'd4, 16'h0001, 32'h01020304, 32'h01028899, 8'd7}, // R7
    '{4'h5, 1'b0, 32'd4, 16'h0001, 32'h01020304, 32'hAABB0304, 8'd6}, // R6
    '{4'h6, 1'b0, 32'd4, 16'h0001, 32'h01020304, 32'h018899AA, 8'd7}, // R7
    '{4'h6, 1'b0, 32'd4, 16'h0003, 32'h01020304, 32'h01020388, 8'd7}, // R7
    '{4'h5, 1'b1, 32'd0, 16'h0003, 32'h01020304, 32'h44020304, 8'd8}  // R8
  };

  task automatic check(string rq, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", rq, got, exp);
    end
  endtask

  // drive a request just after a falling edge; combinational outputs settle by +1ns
  task automatic issue(logic [3:0] o, logic e, logic [31:0] b, logic [15:0] f,
                       logic [31:0] d, logic [31:0] od);
    @(negedge clk);
    req_valid = 1'b1; op = o; big = e; base = b; off = f; sdata = d; old = od;
    #1;
  endtask

  task automatic retire(output logic v, output logic [31:0] r);
    @(negedge clk);
    v = load_valid; r = load_data;
    req_valid = 1'b0;
  endtask

  task automatic load(logic [3:0] o, logic e, logic [31:0] b, logic [15:0] f,
                      logic [31:0] od, output logic v, output logic [31:0] r);
    issue(o, e, b, f, 32'h0, od);
    retire(v, r);
  endtask

  initial begin
    logic v;
    logic [31:0] r, r2;
    repeat (3) @(posedge clk);
    #1;
    check("R11 valid in reset", {31'b0, load_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R11 valid after reset", {31'b0, load_valid}, 32'h0);
    check("R11 idle req", {31'b0, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      load(VECS[i].op, VECS[i].be, VECS[i].base, VECS[i].off, VECS[i].old, v, r);
      check($sformatf("R%0d vec %0d valid", VECS[i].rq, i), {31'b0, v}, 32'h1);
      check($sformatf("R%0d vec %0d data", VECS[i].rq, i), r, VECS[i].exp);
    end

    // R1: word address from base plus positive displacement
    issue(4'h3, 1'b0, 32'h100, 16'h7FFC, 32'h0, 32'h0);
    check("R1 addr", {2'b0, mem_addr}, 32'h0000203F);
    retire(v, r);

    // R9 / R3: store masks and lane replication, word 3
    issue(4'h8, 1'b0, 32'd12, 16'h0, 32'hDEADBEEF, 32'h0);
    check("R9 sw be", {28'b0, mem_be}, 32'hF);
    check("R9 sw data", mem_wdata, 32'hDEADBEEF);
    retire(v, r);
    issue(4'hA, 1'b0, 32'd13, 16'h0, 32'h00000077, 32'h0);
    check("R3 sb le be", {28'b0, mem_be}, 32'h2);
    check("R9 sb data", mem_wdata, 32'h77777777);
    retire(v, r);
    issue(4'hA, 1'b1, 32'd13, 16'h0, 32'h00000055, 32'h0);
    check("R3 sb be be", {28'b0, mem_be}, 32'h4);
    retire(v, r);
    issue(4'h9, 1'b1, 32'd14, 16'h0, 32'h00001234, 32'h0);
    check("R9 sh be be", {28'b0, mem_be}, 32'h3);
    check("R9 sh data", mem_wdata, 32'h12341234);
    retire(v, r);
    load(4'h0, 1'b0, 32'd12, 16'h0, 32'h0, v, r);
    check("R9 readback", r, 32'hDE551234);

    // R2: misaligned word store flags and leaves memory alone
    issue(4'h8, 1'b0, 32'd13, 16'h0, 32'hFFFFFFFF, 32'h0);
    check("R2 sw err", {31'b0, align_err}, 32'h1);
    check("R2 sw no req", {31'b0, mem_req}, 32'h0);
    retire(v, r);
    load(4'h0, 1'b0, 32'd12, 16'h0, 32'h0, v, r);
    check("R2 mem unchanged", r, 32'hDE551234);

    issue(4'h0, 1'b0, 32'd6, 16'h0, 32'h0, 32'h0);
    check("R2 lw err", {31'b0, align_err}, 32'h1);
    retire(v, r);
    check("R2 lw no result", {31'b0, v}, 32'h0);
    issue(4'h1, 1'b0, 32'd5, 16'h0, 32'h0, 32'h0);
    check("R2 lh odd err", {31'b0, align_err}, 32'h1);
    retire(v, r);
    issue(4'h1, 1'b0, 32'd6, 16'h0, 32'h0, 32'h0);
    check("R2 lh even no err", {31'b0, align_err}, 32'h0);
    retire(v, r);
    check("R5 lh even data", r, 32'hFFFF8899);

    // R8: merge at odd offset accesses only its own word
    issue(4'h5, 1'b0, 32'd7, 16'h0, 32'h0, 32'h0);
    check("R8 no err", {31'b0, align_err}, 32'h0);
    check("R8 word addr", {2'b0, mem_addr}, 32'h1);
    retire(v, r);

    // R10: split word at byte 5, big-endian pair
    load(4'h5, 1'b1, 32'd5, 16'h0, 32'h01020304, v, r);
    load(4'h6, 1'b1, 32'd8, 16'h0, r, v, r2);
    check("R10 be pair", r2, 32'h99AABBC0);
    // R10: little-endian pair
    load(4'h6, 1'b0, 32'd5, 16'h0, 32'h01020304, v, r);
    load(4'h5, 1'b0, 32'd8, 16'h0, r, v, r2);
    check("R10 le pair", r2, 32'hF08899AA);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule